// File: doc/BRIEF.md
# Privilege Status Stack Unit

This unit keeps the privilege state of a small pipelined core: a current pair of mode and interrupt-enable bits, plus two saved pairs that form a three-deep stack. An exception entry pushes the stack and drops into kernel mode with interrupts off. A return-from-exception pops it. The decoder presents one system-control instruction per cycle: a register read, a register write or a return-from-exception. The unit decides in the same cycle whether that instruction may run.

Any system-control instruction issued in user mode is refused. The unit raises a coprocessor-unusable trap and the instruction leaves every register untouched. For a refused read, the write-back enable toward the general register file stays low in that same cycle. A status write that commits on a clock edge governs the check of the instruction in the very next cycle. The write that enters user mode therefore completes, and its successor is already checked with user privilege. Besides the status register the unit holds a plain exception-PC word that software can write and read back.

Top module: `cp0_priv_ctrl`

## Requirements
- R1: After reset the unit is in kernel mode with every interrupt-enable bit cleared. A status read returns zero, and user_mode and int_en are low.
- R2: When exc_enter is high, the six status bits shift up by one pair at the next edge. The previous pair moves into the old pair, and the current pair moves into the previous pair. The current pair becomes kernel mode with interrupts disabled. A strobe given in the same cycle has no effect: no trap, no write-back and no register update.
- R3: A permitted return-from-exception copies the previous pair into the current pair and the old pair into the previous pair at the next edge. The old pair keeps its value.
- R4: A read, write or return-from-exception strobe given while the current mode is user raises cpu_trap in that cycle. That instruction changes neither the status register nor the exception-PC word.
- R5: A refused read holds rd_we low in the same cycle in which cpu_trap is high.
- R6: A read in kernel mode raises rd_we in the same cycle, and rd_data carries the selected value. Index 12 returns the six status bits zero-extended. Index 14 returns the exception-PC word. Every other index returns zero.
- R7: A write in kernel mode to index 12 is not trapped. At the next edge it loads wr_data bits 5:0 into the status register and ignores the higher bits. The layout is bit 0 current enable, bit 1 current mode, bit 2 previous enable, bit 3 previous mode, bit 4 old enable and bit 5 old mode, where mode 1 means user and enable 1 means interrupts on.
- R8: If a kernel write sets bit 1 of the status register, the strobe in the immediately following cycle is checked in user mode and trapped.
- R9: A write in kernel mode to index 14 stores the full wr_data word as the exception-PC value.
- R10: user_mode and int_en show the current mode bit and the current enable bit of the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_mfc0 | input | 1 | Register-read instruction strobe |
| ins_mtc0 | input | 1 | Register-write instruction strobe |
| ins_rfe | input | 1 | Return-from-exception strobe |
| reg_idx | input | 5 | Register index for read or write |
| wr_data | input | 32 | Write data for register writes |
| exc_enter | input | 1 | Exception entry; pushes the mode stack |
| rd_data | output | 32 | Read result |
| rd_we | output | 1 | Destination write-enable for a read |
| cpu_trap | output | 1 | Coprocessor-unusable trap |
| user_mode | output | 1 | Current mode, 1 = user |
| int_en | output | 1 | Current interrupt enable |

## Verification
The properties assume the decoder raises at most one of the three instruction strobes in any cycle. They also assume exc_enter may coincide with a strobe, and that the instruction is then discarded. The stimulus sends a single instruction per cycle and includes one deliberate overlap of an exception with a write. It also places a read directly behind the write that enters user mode, so the trap boundary falls exactly where the one-cycle commit rule says it should.

// File: rtl/cp0_priv_pkg.sv
package cp0_priv_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_PUSH = 2'd1,
        ST_POP  = 2'd2,
        ST_LOAD = 2'd3
    } stat_op_e;

    function automatic int unsigned stat_bits(input int unsigned levels);
        return 2 * levels;
    endfunction

endpackage

// File: rtl/cp0_access_gate.sv
module cp0_access_gate (
    input  logic ins_mfc0,
    input  logic ins_mtc0,
    input  logic ins_rfe,
    input  logic exc_enter,
    input  logic user_q,
    output logic go_mfc0,
    output logic go_mtc0,
    output logic go_rfe,
    output logic trap
);
    logic any_ins;
    logic allowed;

    always_comb begin
        any_ins = ins_mfc0 | ins_mtc0 | ins_rfe;
        allowed = ~user_q & ~exc_enter;
        go_mfc0 = ins_mfc0 & allowed;
        go_mtc0 = ins_mtc0 & allowed;
        go_rfe  = ins_rfe  & allowed;
        trap    = any_ins & user_q & ~exc_enter;
    end
endmodule

// File: rtl/cp0_stat_stack.sv
module cp0_stat_stack
    import cp0_priv_pkg::*;
#(
    parameter int unsigned LEVELS = 3,
    localparam int unsigned SW = stat_bits(LEVELS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  stat_op_e      op,
    input  logic [SW-1:0] load_bits,
    output logic [SW-1:0] stat_q
);
    typedef struct packed {
        logic [SW-1:0] stat;
    } stack_t;

    stack_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (op)
            ST_PUSH: begin
                for (int lvl = LEVELS - 1; lvl >= 1; lvl--) begin
                    r_d.stat[2*lvl +: 2] = r_q.stat[2*(lvl-1) +: 2];
                end
                r_d.stat[1:0] = 2'b00;
            end
            ST_POP: begin
                for (int lvl = 0; lvl < LEVELS - 1; lvl++) begin
                    r_d.stat[2*lvl +: 2] = r_q.stat[2*(lvl+1) +: 2];
                end
            end
            ST_LOAD: r_d.stat = load_bits;
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign stat_q = r_q.stat;
endmodule

// File: rtl/cp0_epc_stub.sv
module cp0_epc_stub #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] epc_q
);
    typedef struct packed {
        logic [DATA_W-1:0] epc;
    } epc_t;

    epc_t e_q, e_d;

    always_comb begin
        e_d = e_q;
        if (load) e_d.epc = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign epc_q = e_q.epc;
endmodule

// File: rtl/cp0_priv_ctrl.sv
module cp0_priv_ctrl
    import cp0_priv_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned IDX_W      = 5,
    parameter int unsigned LEVELS     = 3,
    parameter int unsigned STATUS_IDX = 12,
    parameter int unsigned EPC_IDX    = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_mfc0,
    input  logic              ins_mtc0,
    input  logic              ins_rfe,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              exc_enter,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_we,
    output logic              cpu_trap,
    output logic              user_mode,
    output logic              int_en
);
    localparam int unsigned SW = stat_bits(LEVELS);
    localparam logic [IDX_W-1:0] SEL_STAT = IDX_W'(STATUS_IDX);
    localparam logic [IDX_W-1:0] SEL_EPC  = IDX_W'(EPC_IDX);

    logic          go_mfc0, go_mtc0, go_rfe;
    logic [SW-1:0] stat_q;
    logic [DATA_W-1:0] epc_q;
    stat_op_e      op_d;
    logic          epc_load;

    cp0_access_gate u_gate (
        .ins_mfc0  (ins_mfc0),
        .ins_mtc0  (ins_mtc0),
        .ins_rfe   (ins_rfe),
        .exc_enter (exc_enter),
        .user_q    (stat_q[1]),
        .go_mfc0   (go_mfc0),
        .go_mtc0   (go_mtc0),
        .go_rfe    (go_rfe),
        .trap      (cpu_trap)
    );

    always_comb begin
        if (exc_enter)                          op_d = ST_PUSH;
        else if (go_rfe)                        op_d = ST_POP;
        else if (go_mtc0 && reg_idx == SEL_STAT) op_d = ST_LOAD;
        else                                    op_d = ST_HOLD;
        epc_load = go_mtc0 && (reg_idx == SEL_EPC);
    end

    cp0_stat_stack #(.LEVELS(LEVELS)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op_d),
        .load_bits (wr_data[SW-1:0]),
        .stat_q    (stat_q)
    );

    cp0_epc_stub #(.DATA_W(DATA_W)) u_epc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (epc_load),
        .din   (wr_data),
        .epc_q (epc_q)
    );

    always_comb begin
        rd_data = '0;
        if (reg_idx == SEL_STAT)     rd_data = DATA_W'(stat_q);
        else if (reg_idx == SEL_EPC) rd_data = epc_q;
    end

    assign rd_we     = go_mfc0;
    assign user_mode = stat_q[1];
    assign int_en    = stat_q[0];
endmodule

// File: rtl/cp0_priv_chk.sv
module cp0_priv_chk #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned IDX_W      = 5,
    parameter int unsigned LEVELS     = 3,
    parameter int unsigned STATUS_IDX = 12,
    localparam int unsigned SW = 2 * LEVELS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ins_mfc0,
    input logic              ins_mtc0,
    input logic              ins_rfe,
    input logic [IDX_W-1:0]  reg_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              exc_enter,
    input logic              rd_we,
    input logic              cpu_trap,
    input logic              user_mode,
    input logic              int_en,
    input logic [SW-1:0]     stat_q
);
    logic kern_stat_wr;
    assign kern_stat_wr = ins_mtc0 && !user_mode && !exc_enter
                          && (reg_idx == IDX_W'(STATUS_IDX));

    AST_TRAP_NO_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_trap |-> !rd_we);  // R5

    AST_USER_ACCESS_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((ins_mfc0 || ins_mtc0 || ins_rfe) && user_mode && !exc_enter) |-> cpu_trap);  // R4

    AST_KERNEL_NEVER_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        !user_mode |-> !cpu_trap);  // R7

    AST_TRAP_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_trap |=> $stable(stat_q));  // R4

    AST_PUSH_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> (stat_q[SW-1:2] == $past(stat_q[SW-3:0])) && !user_mode && !int_en);  // R2

    AST_POP_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_rfe && !user_mode && !exc_enter) |=>
            (stat_q[SW-3:0] == $past(stat_q[SW-1:2])) && (stat_q[SW-1:SW-2] == $past(stat_q[SW-1:SW-2])));  // R3

    AST_STATUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        kern_stat_wr |=> stat_q == $past(wr_data[SW-1:0]));  // R7

    AST_MODE_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (kern_stat_wr && wr_data[1]) |=> user_mode);  // R8

    AST_OUTPUTS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (user_mode == stat_q[1]) && (int_en == stat_q[0]));  // R10
endmodule

bind cp0_priv_ctrl cp0_priv_chk #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .LEVELS(LEVELS), .STATUS_IDX(STATUS_IDX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ins_mfc0(ins_mfc0), .ins_mtc0(ins_mtc0),
    .ins_rfe(ins_rfe), .reg_idx(reg_idx), .wr_data(wr_data), .exc_enter(exc_enter),
    .rd_we(rd_we), .cpu_trap(cpu_trap), .user_mode(user_mode), .int_en(int_en),
    .stat_q(stat_q)
);

// File: tb/sim_cp0_priv_ctrl.sv
module sim_cp0_priv_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_mfc0 = 1'b0, ins_mtc0 = 1'b0, ins_rfe = 1'b0, exc_enter = 1'b0;
    logic [4:0]  reg_idx = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        rd_we, cpu_trap, user_mode, int_en;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;  // 125 MHz

    cp0_priv_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ins_mfc0(ins_mfc0), .ins_mtc0(ins_mtc0),
        .ins_rfe(ins_rfe), .reg_idx(reg_idx), .wr_data(wr_data), .exc_enter(exc_enter),
        .rd_data(rd_data), .rd_we(rd_we), .cpu_trap(cpu_trap),
        .user_mode(user_mode), .int_en(int_en)
    );

    typedef struct {
        logic        trap;
        logic        we;
        logic [31:0] rdata;
        logic        um;
        logic        ie;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [5:0]  m_stat = '0;
    logic [31:0] m_epc = '0;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    // kind: 0 idle, 1 read, 2 write, 3 rfe, 4 exception, 5 exception with write
    task automatic issue(input int kind, input logic [4:0] idx, input logic [31:0] data,
                         input string tag);
        exp_t e;
        logic user;
        logic exc;
        @(negedge clk);
        ins_mfc0  = (kind == 1);
        ins_mtc0  = (kind == 2) || (kind == 5);
        ins_rfe   = (kind == 3);
        exc_enter = (kind >= 4);
        reg_idx   = idx;
        wr_data   = data;
        user = m_stat[1];
        exc  = (kind >= 4);
        e.trap  = !exc && (kind >= 1) && (kind <= 3) && user;
        e.we    = (kind == 1) && !user;
        e.rdata = (idx == 5'd12) ? {26'b0, m_stat} : (idx == 5'd14) ? m_epc : 32'h0;
        e.um    = user;
        e.ie    = m_stat[0];
        e.tag   = tag;
        sb.push_back(e);
        if (exc) m_stat = {m_stat[3:0], 2'b00};
        else if (!user) begin
            if (kind == 2 && idx == 5'd12) m_stat = data[5:0];
            if (kind == 2 && idx == 5'd14) m_epc = data;
            if (kind == 3) m_stat = {m_stat[5:4], m_stat[5:2]};
        end
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({31'b0, cpu_trap},  {31'b0, e.trap}, {e.tag, " cpu_trap"});
                check({31'b0, rd_we},     {31'b0, e.we},   {e.tag, " rd_we"});
                check({31'b0, user_mode}, {31'b0, e.um},   {e.tag, " user_mode R10"});
                check({31'b0, int_en},    {31'b0, e.ie},   {e.tag, " int_en R10"});
                if (e.we) check(rd_data, e.rdata, {e.tag, " rd_data"});
            end
        end
    end

    initial begin : watchdog
        #200000;
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check({31'b0, user_mode}, 32'h0, "R1 reset user_mode");
        check({31'b0, int_en},    32'h0, "R1 reset int_en");
        check({31'b0, cpu_trap},  32'h0, "R1 reset cpu_trap");

        issue(1, 5'd12, 32'h0, "R1 R6 status read after reset");
        issue(2, 5'd12, 32'hFFFF_FF2D, "R7 kernel status write");
        issue(1, 5'd12, 32'h0, "R7 read back low six bits");
        issue(4, 5'd0,  32'h0, "R2 exception push");
        issue(1, 5'd12, 32'h0, "R2 pushed value");
        issue(3, 5'd0,  32'h0, "R3 rfe pop");
        issue(1, 5'd12, 32'h0, "R3 popped value");
        issue(2, 5'd14, 32'hDEAD_BEEF, "R9 epc write");
        issue(1, 5'd14, 32'h0, "R9 epc read");
        issue(1, 5'd13, 32'h0, "R6 unmapped index reads zero");
        issue(5, 5'd12, 32'h0000_003F, "R2 write under exception ignored");
        issue(1, 5'd12, 32'h0, "R2 status after overlapped push");
        issue(2, 5'd12, 32'h0000_0006, "R7 R8 write entering user mode");
        issue(1, 5'd12, 32'h0, "R5 R8 read right after switch traps");
        issue(2, 5'd12, 32'h0000_0000, "R4 user write trapped");
        issue(2, 5'd14, 32'h1234_5678, "R4 user epc write trapped");
        issue(3, 5'd0,  32'h0, "R4 user rfe trapped");
        issue(4, 5'd0,  32'h0, "R2 exception from user");
        issue(1, 5'd12, 32'h0, "R4 status unchanged by trapped ops");
        issue(1, 5'd14, 32'h0, "R4 epc unchanged by trapped write");
        issue(3, 5'd0,  32'h0, "R3 rfe back to user");
        issue(1, 5'd12, 32'h0, "R5 user read trapped again");
        issue(0, 5'd0,  32'h0, "R10 idle in user");
        issue(0, 5'd0,  32'h0, "R10 final idle");
        repeat (3) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule